// File: doc/BRIEF.md
# Decoupled Two-Read One-Write Memory Streamer

This block sits between a compute datapath and one shared memory port. Once started, it produces the read addresses for two input streams and the write addresses for one output stream. The datapath then only pops operand pairs and pushes results; it never computes an address.

Both read streams walk a window that starts at a programmed input base. For iteration `i`, stream A reads `base_in + i` and stream B reads `base_in + i + 1`. Read requests wait in a request queue. A round-robin arbiter lets them share the single memory port with the queued result writes. Returned words carry a stream tag that steers them into one of two operand queues. The datapath sees a pair only when both queues hold data.

Each result the datapath pushes is paired with the address `base_out + k`, where `k` counts results from zero, and is queued for writing. When the programmed number of iterations has been read and written, the block raises a one-cycle completion pulse.

The controller has three states:
- `ST_IDLE`: waits for `start`. On `start`, it latches the configuration and moves to `ST_STREAM`.
- `ST_STREAM`: generates reads and accepts results. When every read is queued and every result is accepted, it moves to `ST_FLUSH`.
- `ST_FLUSH`: empties the request and write queues, then returns to `ST_IDLE` and pulses `done`.

The read generator alternates between two phases, `PH_A` and `PH_B`, and advances the iteration index after `PH_B`.

Top module: `stream_mem_unit`

## Requirements
- R1: For iteration i, a read tagged 0 to address base_in+i is issued before a read tagged 1 to address base_in+i+1. The tags on `mem_req_tag` alternate 0,1,0,1 from the start of a job. Addresses wrap modulo 2^ADDR_W.
- R2: The k-th result accepted on the `dp_out` handshake (k from 0) is written to memory with `mem_req_write`=1 at address base_out+k, carrying that result's data. Writes leave in push order.
- R3: The k-th operand pair delivered on the `dp_in` handshake is (mem[base_in+k], mem[base_in+k+1]) on (`dp_in_a`, `dp_in_b`). This holds even though read latency varies from 1 to 4 cycles.
- R4: At most one request is presented per cycle. When reads and writes are both pending, grants alternate. A write that is pending but not granted in one cycle is granted in the next cycle.
- R5: A read of a stream is queued only while that stream's issued-but-not-consumed reads are fewer than DATA_DEPTH. No operand is lost when the datapath stalls.
- R6: A job issues exactly `count` reads per stream and `count` writes. After the last write, `done` is high for exactly one cycle, with `busy` already low. `dp_out_ready` is low while idle.
- R7: Base addresses and count are captured on the `start` pulse. A `start` pulse or configuration change while `busy` is high has no effect on the running job.
- R8: A count of zero completes with a `done` pulse and produces no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; honoured only when idle |
| cfg_base_in | input | ADDR_W | Read window base |
| cfg_base_out | input | ADDR_W | Write window base |
| cfg_count | input | CNT_W | Iteration count |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request present this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_tag | output | 1 | Read stream tag (0 = A, 1 = B) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_tag | input | 1 | Stream tag of returned data |
| mem_rsp_data | input | DATA_W | Returned read data |
| dp_in_valid | output | 1 | Operand pair available |
| dp_in_ready | input | 1 | Datapath takes the pair |
| dp_in_a | output | DATA_W | Stream A operand |
| dp_in_b | output | DATA_W | Stream B operand |
| dp_out_valid | input | 1 | Datapath offers a result |
| dp_out_ready | output | 1 | Result accepted this cycle |
| dp_out_data | input | DATA_W | Result value |

## Verification
The assertions assume the following about the memory side:
- It accepts every presented request in the same cycle.
- It returns read words one per cycle, in issue order, with the tag of the request.
- It never returns a word that was not requested.

The bench memory model keeps to these rules. It delays each read by a random 1 to 4 cycles and pushes the response later when needed, so that no response overtakes an earlier one. The datapath model raises `dp_out_valid` only when it holds a result computed from popped operands. Its ready and valid patterns come from `$urandom` with a fixed seed.

// File: rtl/stream_pkg.sv
package stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_FLUSH
    } ctl_state_t;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } rd_phase_t;

endpackage

// File: rtl/stream_fifo.sv
module stream_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == FULLV);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wp_q] <= din;
    end
endmodule

// File: rtl/stream_rd_agu.sv
module stream_rd_agu import stream_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        slot_ok,
    input  logic              q_full,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic              push_tag,
    output logic              finished
);
    logic [CNT_W-1:0] idx_q;
    rd_phase_t        phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            phase_q <= PH_A;
        end else if (load) begin
            idx_q   <= '0;
            phase_q <= PH_A;
        end else if (push) begin
            unique case (phase_q)
                PH_A: phase_q <= PH_B;
                PH_B: begin
                    phase_q <= PH_A;
                    idx_q   <= idx_q + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        finished  = (idx_q == count);
        push_tag  = (phase_q == PH_B);
        push      = run && !finished && !q_full && slot_ok[push_tag];
        push_addr = base + ADDR_W'(idx_q) + ADDR_W'(push_tag);
    end
endmodule

// File: rtl/stream_wr_agu.sv
module stream_wr_agu #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic              q_full,
    input  logic              res_valid,
    output logic              res_ready,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic              finished
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (push) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        finished  = (cnt_q == count);
        res_ready = run && !finished && !q_full;
        push      = res_ready && res_valid;
        push_addr = base + ADDR_W'(cnt_q);
    end
endmodule

// File: rtl/stream_arbiter.sv
module stream_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_valid,
    input  logic wr_valid,
    output logic rd_grant,
    output logic wr_grant
);
    logic last_wr_q;

    always_comb begin
        rd_grant = rd_valid && (!wr_valid || last_wr_q);
        wr_grant = wr_valid && (!rd_valid || !last_wr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     last_wr_q <= 1'b0;
        else if (rd_grant || wr_grant)  last_wr_q <= wr_grant;
    end
endmodule

// File: rtl/stream_mem_unit.sv
module stream_mem_unit import stream_pkg::*; #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 8,
    parameter int REQ_DEPTH  = 4,
    parameter int DATA_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base_in,
    input  logic [ADDR_W-1:0] cfg_base_out,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              busy,
    output logic              done,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic              mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              dp_in_valid,
    input  logic              dp_in_ready,
    output logic [DATA_W-1:0] dp_in_a,
    output logic [DATA_W-1:0] dp_in_b,
    input  logic              dp_out_valid,
    output logic              dp_out_ready,
    input  logic [DATA_W-1:0] dp_out_data
);
    localparam int CRED_W = $clog2(DATA_DEPTH + 1);
    localparam int RQ_W   = ADDR_W + 1;
    localparam int WQ_W   = ADDR_W + DATA_W;
    localparam logic [CRED_W-1:0] CRED_MAX = CRED_W'(DATA_DEPTH);

    ctl_state_t        state_q, state_d;
    logic              done_q;
    logic              load, run;
    logic [ADDR_W-1:0] base_in_q, base_out_q;
    logic [CNT_W-1:0]  count_q;

    logic              rd_push, rd_tag, rd_finished;
    logic [ADDR_W-1:0] rd_addr;
    logic [RQ_W-1:0]   rq_head;
    logic              rq_full, rq_empty;

    logic              wq_push, wr_finished;
    logic [ADDR_W-1:0] wq_addr;
    logic [WQ_W-1:0]   wq_head;
    logic              wq_full, wq_empty;

    logic              rd_avail, wr_avail, rd_grant, wr_grant;
    logic              dp_pop;
    logic [1:0]        slot_ok, dfifo_push, dfifo_full, dfifo_empty;
    logic [DATA_W-1:0] dfifo_dout [2];
    logic [CRED_W-1:0] cred_q [2];

    // configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_in_q  <= '0;
            base_out_q <= '0;
            count_q    <= '0;
        end else if (load) begin
            base_in_q  <= cfg_base_in;
            base_out_q <= cfg_base_out;
            count_q    <= cfg_count;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FLUSH) && (state_d == ST_IDLE);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_STREAM;
            ST_STREAM: if (rd_finished && wr_finished) state_d = ST_FLUSH;
            ST_FLUSH:  if (rq_empty && wq_empty) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = done_q;
        load = (state_q == ST_IDLE) && start;
        run  = (state_q == ST_STREAM);
    end

    stream_rd_agu #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd_agu (
        .clk(clk), .rst_n(rst_n), .load(load), .run(run),
        .base(base_in_q), .count(count_q), .slot_ok(slot_ok), .q_full(rq_full),
        .push(rd_push), .push_addr(rd_addr), .push_tag(rd_tag),
        .finished(rd_finished)
    );

    stream_fifo #(.WIDTH(RQ_W), .DEPTH(REQ_DEPTH)) u_req_q (
        .clk(clk), .rst_n(rst_n), .push(rd_push), .din({rd_tag, rd_addr}),
        .pop(rd_grant), .dout(rq_head), .full(rq_full), .empty(rq_empty)
    );

    stream_wr_agu #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr_agu (
        .clk(clk), .rst_n(rst_n), .load(load), .run(run),
        .base(base_out_q), .count(count_q), .q_full(wq_full),
        .res_valid(dp_out_valid), .res_ready(dp_out_ready),
        .push(wq_push), .push_addr(wq_addr), .finished(wr_finished)
    );

    stream_fifo #(.WIDTH(WQ_W), .DEPTH(REQ_DEPTH)) u_wr_q (
        .clk(clk), .rst_n(rst_n), .push(wq_push), .din({wq_addr, dp_out_data}),
        .pop(wr_grant), .dout(wq_head), .full(wq_full), .empty(wq_empty)
    );

    assign rd_avail = !rq_empty;
    assign wr_avail = !wq_empty;

    stream_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_avail), .wr_valid(wr_avail),
        .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    always_comb begin
        mem_req_valid = rd_grant || wr_grant;
        mem_req_write = wr_grant;
        mem_req_addr  = wr_grant ? wq_head[WQ_W-1:DATA_W] : rq_head[ADDR_W-1:0];
        mem_req_wdata = wq_head[DATA_W-1:0];
        mem_req_tag   = rd_grant && rq_head[RQ_W-1];
    end

    assign dp_in_valid = !dfifo_empty[0] && !dfifo_empty[1];
    assign dp_pop      = dp_in_valid && dp_in_ready;
    assign dp_in_a     = dfifo_dout[0];
    assign dp_in_b     = dfifo_dout[1];

    for (genvar s = 0; s < 2; s++) begin : g_stream
        logic inc;
        assign inc          = rd_push && (rd_tag == s[0]);
        assign slot_ok[s]   = (cred_q[s] < CRED_MAX);
        assign dfifo_push[s] = mem_rsp_valid && (mem_rsp_tag == s[0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cred_q[s] <= '0;
            else        cred_q[s] <= cred_q[s] + CRED_W'(inc) - CRED_W'(dp_pop);
        end

        stream_fifo #(.WIDTH(DATA_W), .DEPTH(DATA_DEPTH)) u_data_q (
            .clk(clk), .rst_n(rst_n), .push(dfifo_push[s]), .din(mem_rsp_data),
            .pop(dp_pop), .dout(dfifo_dout[s]), .full(dfifo_full[s]),
            .empty(dfifo_empty[s])
        );
    end
endmodule

// File: rtl/stream_mem_unit_chk.sv
module stream_mem_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       dp_out_ready,
    input logic       rd_grant,
    input logic       wr_grant,
    input logic       wr_avail,
    input logic [1:0] dfifo_push,
    input logic [1:0] dfifo_full
);
    assert_no_overflow_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dfifo_push[0] |-> !dfifo_full[0]);
    assert_no_overflow_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dfifo_push[1] |-> !dfifo_full[1]);
    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_grant, wr_grant}));
    assert_write_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_avail && !wr_grant) |=> wr_grant);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_idle_no_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dp_out_ready);
endmodule

bind stream_mem_unit stream_mem_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .dp_out_ready(dp_out_ready), .rd_grant(rd_grant), .wr_grant(wr_grant),
    .wr_avail(wr_avail), .dfifo_push(dfifo_push), .dfifo_full(dfifo_full)
);

// File: tb/stream_mem_unit_bench.sv
module stream_mem_unit_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int DDEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_base_in = '0, cfg_base_out = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          busy, done;
    logic          mem_req_valid, mem_req_write, mem_req_tag;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0, mem_rsp_tag = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          dp_in_valid, dp_in_ready = 1'b0;
    logic [DW-1:0] dp_in_a, dp_in_b;
    logic          dp_out_valid = 1'b0, dp_out_ready;
    logic [DW-1:0] dp_out_data = '0;

    always #4 clk = ~clk;

    stream_mem_unit #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
                      .REQ_DEPTH(4), .DATA_DEPTH(DDEPTH)) u_stream_mem_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_base_in(cfg_base_in), .cfg_base_out(cfg_base_out), .cfg_count(cfg_count),
        .busy(busy), .done(done),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data),
        .dp_in_valid(dp_in_valid), .dp_in_ready(dp_in_ready),
        .dp_in_a(dp_in_a), .dp_in_b(dp_in_b),
        .dp_out_valid(dp_out_valid), .dp_out_ready(dp_out_ready),
        .dp_out_data(dp_out_data)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [AW-1:0] j_bin, j_bout;
    int  rd_seen [2];
    int  rd_total, pop_cnt, wr_seen, out_push_cnt, any_req;
    bit  wr_wait_prev, seen_done;
    int  rdy_pct, val_pct;
    int  last_due;
    int  rsp_due [$];
    bit  rsp_tag [$];
    logic [DW-1:0] rsp_dat [$];
    logic [DW-1:0] res_q [$];

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        return DW'(a * 16'd37 + 16'h1234) ^ DW'(a >> 3);
    endfunction

    function automatic logic [DW-1:0] expres(input int k);
        return memval(j_bin + AW'(k)) + memval(j_bin + AW'(k + 1));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit is_wr;
        int pend;
        @(negedge clk);
        cyc++;
        // memory side
        is_wr = mem_req_valid && mem_req_write;
        pend  = out_push_cnt - wr_seen;
        if (wr_wait_prev) check(is_wr, "R4", "write granted one cycle after wait", int'(is_wr), 1);
        wr_wait_prev = (pend > 0) && !is_wr;
        if (mem_req_valid) begin
            any_req++;
            if (mem_req_write) begin
                check(mem_req_addr == j_bout + AW'(wr_seen), "R2", "write address",
                      int'(mem_req_addr), int'(j_bout + AW'(wr_seen)));
                check(mem_req_wdata == expres(wr_seen), "R2", "write data",
                      int'(mem_req_wdata), int'(expres(wr_seen)));
                wr_seen++;
            end else begin
                int t;
                int lat;
                t = int'(mem_req_tag);
                check(t == (rd_total % 2), "R1", "read tag order", t, rd_total % 2);
                check(mem_req_addr == j_bin + AW'(rd_seen[t] + t), "R1", "read address",
                      int'(mem_req_addr), int'(j_bin + AW'(rd_seen[t] + t)));
                rd_seen[t]++;
                rd_total++;
                check(rd_seen[t] - pop_cnt <= DDEPTH, "R5", "reads in flight per stream",
                      rd_seen[t] - pop_cnt, DDEPTH);
                lat = 1 + int'($urandom % 4);
                last_due = (cyc + lat > last_due + 1) ? cyc + lat : last_due + 1;
                rsp_due.push_back(last_due);
                rsp_tag.push_back(t[0]);
                rsp_dat.push_back(memval(mem_req_addr));
            end
        end
        if (rsp_due.size() > 0 && rsp_due[0] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_tag   = rsp_tag.pop_front();
            mem_rsp_data  = rsp_dat.pop_front();
            void'(rsp_due.pop_front());
        end else begin
            mem_rsp_valid = 1'b0;
        end
        // datapath input side
        dp_in_ready = (int'($urandom % 100) < rdy_pct);
        if (dp_in_valid && dp_in_ready) begin
            check(dp_in_a == memval(j_bin + AW'(pop_cnt)), "R3", "operand A",
                  int'(dp_in_a), int'(memval(j_bin + AW'(pop_cnt))));
            check(dp_in_b == memval(j_bin + AW'(pop_cnt + 1)), "R3", "operand B",
                  int'(dp_in_b), int'(memval(j_bin + AW'(pop_cnt + 1))));
            res_q.push_back(dp_in_a + dp_in_b);
            pop_cnt++;
        end
        // datapath output side
        dp_out_valid = (res_q.size() > 0) && (int'($urandom % 100) < val_pct);
        dp_out_data  = (res_q.size() > 0) ? res_q[0] : '0;
        if (dp_out_valid && dp_out_ready) begin
            void'(res_q.pop_front());
            out_push_cnt++;
        end
        if (done) begin
            seen_done = 1'b1;
            check(!busy, "R6", "busy low with done", int'(busy), 0);
        end
    endtask

    task automatic run_job(input logic [AW-1:0] bin, input logic [AW-1:0] bout,
                           input int cnt, input int rp, input int vp, input bit disturb);
        int n;
        j_bin = bin; j_bout = bout;
        rd_seen[0] = 0; rd_seen[1] = 0;
        rd_total = 0; pop_cnt = 0; wr_seen = 0; out_push_cnt = 0; any_req = 0;
        wr_wait_prev = 1'b0; seen_done = 1'b0;
        rdy_pct = rp; val_pct = vp;
        cfg_base_in = bin; cfg_base_out = bout; cfg_count = CW'(cnt);
        start = 1'b1;
        step();
        start = 1'b0;
        n = 0;
        while (!seen_done && n < 4000) begin
            if (disturb && n == 5) begin
                cfg_base_in = ~bin; cfg_base_out = bin; cfg_count = 8'd3; start = 1'b1;
            end else if (disturb && n == 6) begin
                start = 1'b0;
            end
            step();
            n++;
        end
        start = 1'b0;
        check(seen_done, disturb ? "R7" : "R6", "job completed", int'(seen_done), 1);
        check(rd_seen[0] == cnt && rd_seen[1] == cnt, disturb ? "R7" : "R6",
              "reads per stream", rd_seen[0] + rd_seen[1], 2 * cnt);
        check(wr_seen == cnt, disturb ? "R7" : "R6", "writes issued", wr_seen, cnt);
        if (cnt == 0) check(any_req == 0, "R8", "no memory traffic on zero count", any_req, 0);
        step();
        check(!done, "R6", "done lasts one cycle", int'(done), 0);
        check(!mem_req_valid, "R6", "no request after done", int'(mem_req_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        last_due = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R6", "reset idle", int'(busy) + int'(done), 0);
        check(!mem_req_valid && !dp_in_valid, "R6", "reset no traffic",
              int'(mem_req_valid) + int'(dp_in_valid), 0);
        check(!dp_out_ready, "R6", "reset not accepting results", int'(dp_out_ready), 0);
        run_job(16'h0100, 16'h8000, 10, 100, 100, 1'b0);
        run_job(16'h0200, 16'h9000, 20, 50, 60, 1'b0);
        run_job(16'h0300, 16'hA000, 0, 100, 100, 1'b0);
        run_job(16'h0400, 16'hB000, 1, 100, 100, 1'b0);
        run_job(16'h0500, 16'hC000, 12, 70, 70, 1'b1);
        run_job(16'hFFF0, 16'hFFF8, 30, 60, 80, 1'b0);
        run_job(16'h1000, 16'h2000, 60, 20, 90, 1'b0);
        run_job(16'h3000, 16'h4000, 40, 100, 30, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule